// File: doc/BRIEF.md
# DMA Burst Splitter with 16-Byte Boundary Handling

This block takes one buffer transfer request, given as a start byte address and a byte length, and turns it into a series of bus master bursts of 32-bit words. Each burst carries 1, 2, 3 or 4 words. A burst never crosses a 16-byte aligned address boundary. Bursts shorter than four words appear only where the buffer's first or last word forces them.

The block presents one burst at a time on a request/acknowledge port. It holds the word address, the word count and the valid byte count of the burst's final word until the bus acknowledges. It then moves its cursor and presents the next burst. When the last burst has been acknowledged, it raises a one-cycle completion pulse. An unaligned start or end is covered with whole words. The valid byte count of the final word is reported next to the last burst. Moving the data itself is left to the surrounding logic.

The control is a three-state machine:
- IDLE accepts a request.
- ISSUE presents bursts until the final one is acknowledged.
- DONE raises the completion pulse for one cycle and then returns to IDLE.

The transitions are:
- IDLE→ISSUE on a request with a nonzero length.
- IDLE→DONE on a request with zero length.
- ISSUE→ISSUE on an acknowledge that is not the final one.
- ISSUE→DONE on the final acknowledge.
- DONE→IDLE always.

Top module: `dma_burst_splitter`

## Requirements
- R1: After reset `req_ready` is 1, and `bus_req` and `xfer_done` are 0.
- R2: While `bus_req` is 1, `bus_words` is between 1 and 4, and `bus_addr[3:2] + bus_words` does not exceed 4, so no burst crosses a 16-byte boundary.
- R3: Each burst length is the smallest of three values: 4, the words left before the next 16-byte boundary, and the words left in the buffer.
- R4: While `bus_req` is 1 and `bus_ack` is 0, the next cycle still has `bus_req` at 1 with `bus_addr` and `bus_words` unchanged.
- R5: After a non-final burst is acknowledged, the next burst starts at the previous `bus_addr` plus 4 times the previous `bus_words`.
- R6: The bursts of one request cover exactly ceil((req_addr mod 4 + req_len) / 4) words. `bus_last` is 1 only on the final burst. `xfer_done` is 1 for exactly the one cycle after the final acknowledge.
- R7: A request with `req_len` equal to 0 issues no burst, and `xfer_done` is 1 in the cycle after acceptance.
- R8: `bus_tail_bytes` is 4 on every non-final burst. On the final burst it is (req_addr mod 4 + req_len) mod 4, or 4 when that value is 0.
- R9: `bus_addr[1:0]` is always 0. An unaligned start address is rounded down to its word, and the offset counts toward the covered bytes.
- R10: `req_valid` has no effect while `req_ready` is 0. A request made during a transfer changes neither the bursts nor the completion of that transfer.
- R11: `req_ready` is 1 only in IDLE, and it is 0 in the cycle where `xfer_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request strobe, taken when req_ready is 1 |
| req_addr | input | ADDR_W | Start byte address of the buffer |
| req_len | input | LEN_W | Buffer length in bytes |
| req_ready | output | 1 | Idle and able to accept a request |
| bus_req | output | 1 | Burst presented to the bus master port |
| bus_addr | output | ADDR_W | Word-aligned byte address of the burst |
| bus_words | output | 3 | Burst length in words, 1 to 4 |
| bus_last | output | 1 | This burst is the final one of the buffer |
| bus_tail_bytes | output | 3 | Valid bytes in the burst's final word, 1 to 4 |
| bus_ack | input | 1 | Bus accepted and finished the presented burst |
| xfer_done | output | 1 | One-cycle pulse: the whole buffer has been covered |

## Verification
The bench targets four kinds of corner case:
- Starts that sit one to three words below a 16-byte boundary. A design that ignored the boundary would issue a 4-word burst straddling it.
- Starts whose byte offset pushes the final word over. A design that dropped the offset would cover one word too few or report the wrong tail byte count.
- Zero-length requests. A wrong design would issue a stray burst.
- A request that arrives during a slow acknowledge. A wrong design would let it reload the cursor and corrupt the transfer in progress.

The largest buffer, 2047 bytes, checks that the word count neither truncates nor wraps.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    // Words per 16-byte aligned window; also the longest burst.
    localparam int unsigned WIN_WORDS = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DONE
    } dbs_state_e;
endpackage

// File: rtl/dbs_cursor.sv
module dbs_cursor #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 12,
    localparam int unsigned WA_W  = ADDR_W - 2,
    localparam int unsigned WL_W  = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              advance,
    input  logic [2:0]        step,
    output logic [WA_W-1:0]   waddr,
    output logic [WL_W-1:0]   words_left,
    output logic [1:0]        tail_mod
);
    logic [LEN_W:0] end_round;

    // Bytes from the word-aligned start to the buffer end, rounded up to words.
    assign end_round = {1'b0, start_len} + (LEN_W+1)'(start_addr[1:0]) + (LEN_W+1)'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr      <= '0;
            words_left <= '0;
            tail_mod   <= '0;
        end else if (load) begin
            waddr      <= start_addr[ADDR_W-1:2];
            words_left <= end_round[LEN_W:2];
            tail_mod   <= start_len[1:0] + start_addr[1:0];
        end else if (advance) begin
            waddr      <= waddr + WA_W'(step);
            words_left <= words_left - WL_W'(step);
        end
    end
endmodule

// File: rtl/dbs_burst_calc.sv
module dbs_burst_calc #(
    parameter int unsigned LEN_W = 12,
    localparam int unsigned WL_W = LEN_W - 1
) (
    input  logic [1:0]      waddr_lo,
    input  logic [WL_W-1:0] words_left,
    input  logic [1:0]      tail_mod,
    output logic [2:0]      words,
    output logic            last,
    output logic [2:0]      tail_bytes
);
    import dbs_pkg::*;

    logic [2:0] room;
    logic [2:0] cap;

    always_comb begin
        room = 3'(WIN_WORDS) - {1'b0, waddr_lo};
        cap  = (words_left >= WL_W'(WIN_WORDS)) ? 3'(WIN_WORDS) : words_left[2:0];
        words = (room < cap) ? room : cap;
        last  = (words_left == WL_W'(words));
        tail_bytes = (last && tail_mod != 2'd0) ? {1'b0, tail_mod} : 3'd4;
    end
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 12,
    localparam int unsigned WA_W  = ADDR_W - 2,
    localparam int unsigned WL_W  = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_words,
    output logic              bus_last,
    output logic [2:0]        bus_tail_bytes,
    input  logic              bus_ack,
    output logic              xfer_done
);
    import dbs_pkg::*;

    dbs_state_e      state_q, state_d;
    logic            load, advance;
    logic [WA_W-1:0] waddr;
    logic [WL_W-1:0] words_left;
    logic [1:0]      tail_mod;
    logic [2:0]      burst_words;
    logic            burst_last;
    logic [2:0]      burst_tail;

    assign load    = req_valid && (state_q == ST_IDLE);
    assign advance = bus_ack && (state_q == ST_ISSUE);

    dbs_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (req_addr),
        .start_len  (req_len),
        .advance    (advance),
        .step       (burst_words),
        .waddr      (waddr),
        .words_left (words_left),
        .tail_mod   (tail_mod)
    );

    dbs_burst_calc #(.LEN_W(LEN_W)) u_calc (
        .waddr_lo   (waddr[1:0]),
        .words_left (words_left),
        .tail_mod   (tail_mod),
        .words      (burst_words),
        .last       (burst_last),
        .tail_bytes (burst_tail)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (req_len == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (bus_ack && burst_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        bus_req        = 1'b0;
        xfer_done      = 1'b0;
        bus_addr       = {waddr, 2'b00};
        bus_words      = burst_words;
        bus_last       = burst_last;
        bus_tail_bytes = burst_tail;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: bus_req   = 1'b1;
            ST_DONE:  xfer_done = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_burst_splitter_checker.sv
module dma_burst_splitter_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LEN_W-1:0]  req_len,
    input logic              req_ready,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_words,
    input logic              bus_last,
    input logic              bus_ack,
    input logic              xfer_done
);
    p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_words >= 3'd1 && bus_words <= 3'd4 &&
                     ({1'b0, bus_addr[3:2]} + bus_words) <= 3'd4));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_words)));

    p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_last) |=>
            (bus_req && bus_addr == $past(bus_addr) + ADDR_W'({$past(bus_words), 2'b00})));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_last) |=> (xfer_done && !bus_req));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!xfer_done && req_ready));

    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_len == '0) |=> (xfer_done && !bus_req));

    p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] == 2'b00));

    p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, bus_req, xfer_done}) == 1);
endmodule

bind dma_burst_splitter dma_burst_splitter_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_ready (req_ready),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_words (bus_words),
    .bus_last  (bus_last),
    .bus_ack   (bus_ack),
    .xfer_done (xfer_done)
);

// File: tb/dma_burst_splitter_test.sv
module dma_burst_splitter_test;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_ready;
    logic              bus_req;
    logic [ADDR_W-1:0] bus_addr;
    logic [2:0]        bus_words;
    logic              bus_last;
    logic [2:0]        bus_tail_bytes;
    logic              bus_ack = 1'b0;
    logic              xfer_done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_words(bus_words), .bus_last(bus_last),
        .bus_tail_bytes(bus_tail_bytes), .bus_ack(bus_ack), .xfer_done(xfer_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one request and follow every burst against a model of R2/R3/R5/R6/R8/R9.
    // delay: cycles with bus_ack low before each acknowledge.
    // poke: drive a foreign request during the waits (R10).
    task automatic run_xfer(input int addr, input int len, input int delay, input bit poke);
        int cur, left, tail, off, n, room, nb, exp_n;
        off  = addr & 3;
        cur  = addr & ~3;
        left = (off + len + 3) / 4;
        tail = (off + len) % 4;
        if (tail == 0) tail = 4;
        exp_n = 0;
        @(negedge clk);
        req_addr = ADDR_W'(addr);
        req_len  = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            check(bus_req == 1'b0, "R7", "no burst on zero length", bus_req, 0);
            check(xfer_done == 1'b1, "R7", "done after zero length", xfer_done, 1);
        end else begin
            nb = 0;
            while (left > 0) begin
                room = 4 - ((cur >> 2) & 3);
                n = (left < 4) ? left : 4;
                if (room < n) n = room;
                check(bus_req == 1'b1, "R6", "burst presented", bus_req, 1);
                check(bus_addr == ADDR_W'(cur), "R9", "burst address", bus_addr, cur);
                check(int'(bus_words) == n, "R3", "burst length", bus_words, n);
                check(bus_last == (left == n), "R6", "last flag", bus_last, left == n);
                check(int'(bus_tail_bytes) == ((left == n) ? tail : 4), "R8", "tail bytes",
                      bus_tail_bytes, (left == n) ? tail : 4);
                for (int d = 0; d < delay; d++) begin
                    if (poke) begin
                        req_valid = 1'b1;
                        req_addr  = 32'hF0;
                        req_len   = 12'd0;
                    end
                    @(negedge clk);
                    req_valid = 1'b0;
                    check(bus_req == 1'b1 && bus_addr == ADDR_W'(cur) && int'(bus_words) == n,
                          poke ? "R10" : "R4", "held while waiting", bus_addr, cur);
                end
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
                cur  = cur + 4 * n;
                left = left - n;
                nb++;
            end
            check(xfer_done == 1'b1, "R6", "done after final ack", xfer_done, 1);
            check(bus_req == 1'b0, "R6", "no extra burst", bus_req, 0);
            exp_n = nb;
        end
        check(req_ready == 1'b0, "R11", "not ready during done", req_ready, 0);
        @(negedge clk);
        check(xfer_done == 1'b0 && req_ready == 1'b1, "R11", "done is one cycle, back to idle",
              xfer_done, 0);
        if (exp_n < 0) $display("unreachable");
    endtask

    task automatic test_reset;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(bus_req == 1'b0, "R1", "no burst in reset", bus_req, 0);
        check(xfer_done == 1'b0, "R1", "no done in reset", xfer_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && bus_req == 1'b0, "R1", "idle after reset", req_ready, 1);
    endtask

    task automatic test_aligned;          // R3: full 4-word bursts
        run_xfer(32'h100, 64, 0, 1'b0);
    endtask

    task automatic test_near_boundary;    // R2, R3: 1-word head then 4 words, tail 2
        run_xfer(32'h0E, 20, 0, 1'b0);
    endtask

    task automatic test_short_tail;       // R8: 3-word head, 1-word final with 1 byte
        run_xfer(32'h24, 13, 1, 1'b0);
    endtask

    task automatic test_zero_len;         // R7
        run_xfer(32'h40, 0, 0, 1'b0);
        run_xfer(32'h43, 0, 0, 1'b0);
    endtask

    task automatic test_rx_buffer;        // R4, R5: 128-byte buffer with slow acks
        run_xfer(32'h200, 128, 2, 1'b0);
    endtask

    task automatic test_low_bits;         // R9: offset 3, 8 bytes -> 3 words, tail 3
        run_xfer(32'h13, 8, 0, 1'b0);
    endtask

    task automatic test_busy_request;     // R10: foreign request while waiting
        run_xfer(32'h34, 40, 2, 1'b1);
    endtask

    task automatic test_max_len;          // R6: 2047 bytes -> 512 words, tail 3
        run_xfer(32'h4, 2047, 0, 1'b0);
    endtask

    initial begin
        test_reset();
        test_aligned();
        test_near_boundary();
        test_short_tail();
        test_zero_len();
        test_rx_buffer();
        test_low_bits();
        test_busy_request();
        test_max_len();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule